// File: doc/BRIEF.md
# SAR ADC Control Sequencer

This block is the digital half of a four-input, 12-bit successive-approximation converter. Software reaches it through a byte-wide register port with four addresses: a control register, a clock/power register and two read-only result registers. The block divides the system clock down to a converter tick, decides whether the converter is powered, and drives the channel select and per-pin analog enables towards the analog front end.

A conversion starts with a two-step handshake on the start bit. Raising the bit resets the converter and marks it busy. Dropping the bit launches a conversion. The sequencer spends one converter tick sampling, then runs a 12-step binary search, MSB first. On each step it drives a trial code to an external DAC and reads back one comparator bit. When the last bit is decided, both result registers are loaded and the busy flag clears, in the same cycle.

Top module: `sar_seq_top`

## Requirements
- R1: After reset the control register (address 0) reads 0x40 (busy flag at bit 6 set, all other bits 0), the clock/power register (address 1) reads 0x00, `pin_analog` is 0 and `adc_pd` is 1.
- R2: A write to address 0 that takes the start bit (bit 7) from 0 to 1 aborts any conversion in progress, sets the busy flag (bit 6) to 1 in the next cycle, and leaves both result registers unchanged.
- R3: A write to address 0 that takes the start bit from 1 to 0 launches a conversion. The busy flag stays 1 for the sample tick plus 12 search ticks and reads 0 exactly 13·D system cycles after the launching write, where D is the selected division. The flag only falls on a converter tick.
- R4: The search is MSB first, with `cmp_in`=1 meaning the input is at or above `trial_code` (keep the bit). The final result equals the input value seen on the sampled channel.
- R5: Bits 1:0 of address 0 select the channel (00 = input 0 … 11 = input 3). `chan_sel` takes the field value when the conversion is launched, and later writes to the field do not change `chan_sel` or the result of that conversion.
- R6: Bits 5:2 of address 0 drive `pin_analog[3:0]`. When all four are 0, `adc_pd` is 1, no converter tick is produced, and a running conversion freezes and resumes once a pin is enabled again.
- R7: Bit 6 of address 1 is a power-off control that resets to 0. When it is 1, `adc_pd` is 1, ticks stop, and a running conversion freezes.
- R8: Bits 2:0 of address 1 select the converter tick rate: 100 every cycle, 000 every 2, 101 every 4, 001 every 8, 110 every 16, 010 every 32.
- R9: The clock codes 011 and 111 stop the tick, and a running conversion freezes without completing.
- R10: Address 2 reads result bits 11:4. Address 3 reads result bits 3:0 in bits 7:4, with bits 3:0 reading 0. Bits 7 and 5:3 of address 1 read 0.
- R11: Both result registers change only in the cycle in which the busy flag falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cmp_in | input | 1 | Comparator result: input at or above `trial_code` |
| trial_code | output | 12 | Trial code to the external DAC |
| chan_sel | output | 2 | Channel select latched at launch |
| pin_analog | output | 4 | Per-pin analog enables |
| adc_pd | output | 1 | Converter power-down |
| conv_tick | output | 1 | Converter clock enable, one system cycle wide |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are valid whenever `bus_wr` is high. They also assume that `cmp_in` is a function of the current `trial_code` and channel only, so a frozen conversion sees the same comparator answer when it resumes. The bench drives every write half a cycle before the capturing edge and holds it for one full cycle. It models the comparator as a continuous comparison of `trial_code` against a per-channel value indexed by `chan_sel`. Clock codes, pin enables and the power bit are changed only by whole register writes, so a tick never has to be judged against a half-updated select.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   localparam int BUS_W = 8;
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_CLKP = 2'd1;
   localparam logic [1:0] A_RESH = 2'd2;
   localparam logic [1:0] A_RESL = 2'd3;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SAMPLE = 2'd1,
      ST_SEARCH = 2'd2
   } sar_state_e;

   // log2 of the division for a clock-select code; the low two bits
   // give twice the exponent, a clear top bit adds one.
   function automatic logic [2:0] div_log2(input logic [2:0] sel);
      div_log2 = {sel[1:0], 1'b0} + {2'b00, ~sel[2]};
   endfunction

   function automatic logic sel_legal(input logic [2:0] sel);
      sel_legal = (sel[1:0] != 2'b11);
   endfunction

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
   parameter int MAX_LOG = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic [2:0] sel,
   output logic       tick
);
   import sar_seq_pkg::*;

   localparam int CNT_W = (MAX_LOG < 1) ? 1 : MAX_LOG;

   generate
      if (MAX_LOG < 5) begin : g_bad_log
         $error("sar_clk_div: MAX_LOG must cover the division by 32");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   limit;
   logic             active;

   assign active = run && sel_legal(sel);
   assign limit  = ({{CNT_W{1'b0}}, 1'b1} << div_log2(sel)) - 1'b1;
   assign tick   = active && ({1'b0, cnt_q} >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || !active || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sar_regs.sv
module sar_regs #(
   parameter int RES_W = 12,
   parameter int N_CH  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic             done,
   input  logic [RES_W-1:0] done_val,
   output logic             launch,
   output logic             abort,
   output logic             start_q,
   output logic             eoc_q,
   output logic [N_CH-1:0]  pins_q,
   output logic [1:0]       chan_q,
   output logic [1:0]       new_chan,
   output logic             poff_q,
   output logic [2:0]       sel_q,
   output logic [RES_W-1:0] res_q
);
   import sar_seq_pkg::*;

   localparam int LO_BITS = RES_W - 8;

   generate
      if (N_CH != 4) begin : g_bad_ch
         $error("sar_regs: control layout holds exactly four pin enables");
      end
      if (RES_W <= 8 || RES_W > 16) begin : g_bad_res
         $error("sar_regs: result must span two bytes");
      end
   endgenerate

   logic wr_ctrl, wr_clkp;

   assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
   assign wr_clkp  = bus_wr && (bus_addr == A_CLKP);
   assign abort    = wr_ctrl && bus_wdata[7] && !start_q;
   assign launch   = wr_ctrl && !bus_wdata[7] && start_q;
   assign new_chan = bus_wdata[1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         pins_q  <= '0;
         chan_q  <= '0;
      end else if (wr_ctrl) begin
         start_q <= bus_wdata[7];
         pins_q  <= bus_wdata[5:2];
         chan_q  <= bus_wdata[1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poff_q <= 1'b0;
         sel_q  <= 3'b000;
      end else if (wr_clkp) begin
         poff_q <= bus_wdata[6];
         sel_q  <= bus_wdata[2:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_q <= 1'b1;
      end else if (abort) begin
         eoc_q <= 1'b1;
      end else if (done) begin
         eoc_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
      end else if (done && !abort) begin
         res_q <= done_val;
      end
   end

   logic [7:0] res_hi, res_lo;
   assign res_hi = res_q[RES_W-1 -: 8];

   generate
      if (LO_BITS == 8) begin : g_lo_full
         assign res_lo = res_q[7:0];
      end else begin : g_lo_part
         assign res_lo = {res_q[LO_BITS-1:0], {(8-LO_BITS){1'b0}}};
      end
   endgenerate

   always_comb begin
      unique case (bus_addr)
         A_CTRL:  bus_rdata = {start_q, eoc_q, pins_q, chan_q};
         A_CLKP:  bus_rdata = {1'b0, poff_q, 3'b000, sel_q};
         A_RESH:  bus_rdata = res_hi;
         default: bus_rdata = res_lo;
      endcase
   end

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
   parameter int RES_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             launch,
   input  logic             abort,
   input  logic [1:0]       launch_chan,
   input  logic             cmp_in,
   output logic [RES_W-1:0] trial,
   output logic [1:0]       chan,
   output logic             done,
   output logic [RES_W-1:0] done_val
);
   import sar_seq_pkg::*;

   localparam int IDX_W = $clog2(RES_W);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

   sar_state_e       st_q;
   logic [RES_W-1:0] sar_q;
   logic [IDX_W-1:0] idx_q;
   logic [RES_W-1:0] decided;

   always_comb begin
      decided = sar_q;
      if (!cmp_in) decided[idx_q] = 1'b0;
   end

   assign done     = (st_q == ST_SEARCH) && tick && (idx_q == '0) && !abort;
   assign done_val = decided;
   assign trial    = sar_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         sar_q <= '0;
         idx_q <= '0;
         chan  <= '0;
      end else if (abort) begin
         st_q <= ST_IDLE;
      end else if (launch) begin
         st_q  <= ST_SAMPLE;
         sar_q <= '0;
         chan  <= launch_chan;
      end else if (tick) begin
         unique case (st_q)
            ST_SAMPLE: begin
               st_q           <= ST_SEARCH;
               sar_q          <= '0;
               sar_q[TOP_IDX] <= 1'b1;
               idx_q          <= TOP_IDX;
            end
            ST_SEARCH: begin
               if (idx_q == '0) begin
                  st_q  <= ST_IDLE;
                  sar_q <= decided;
               end else begin
                  sar_q            <= decided;
                  sar_q[idx_q - 1] <= 1'b1;
                  idx_q            <= idx_q - 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
   parameter int RES_W   = 12,
   parameter int N_CH    = 4,
   parameter int MAX_LOG = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic             cmp_in,
   output logic [RES_W-1:0] trial_code,
   output logic [1:0]       chan_sel,
   output logic [N_CH-1:0]  pin_analog,
   output logic             adc_pd,
   output logic             conv_tick
);

   logic             launch, abort, done;
   logic             start_q, eoc_q, poff_q;
   logic [N_CH-1:0]  pins_q;
   logic [1:0]       chan_q, new_chan;
   logic [2:0]       sel_q;
   logic [RES_W-1:0] res_q, done_val;

   sar_regs #(.RES_W(RES_W), .N_CH(N_CH)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .done(done), .done_val(done_val),
      .launch(launch), .abort(abort),
      .start_q(start_q), .eoc_q(eoc_q), .pins_q(pins_q),
      .chan_q(chan_q), .new_chan(new_chan),
      .poff_q(poff_q), .sel_q(sel_q), .res_q(res_q)
   );

   assign adc_pd     = poff_q || (pins_q == '0);
   assign pin_analog = pins_q;

   sar_clk_div #(.MAX_LOG(MAX_LOG)) u_div (
      .clk(clk), .rst_n(rst_n),
      .run(!adc_pd), .restart(launch || abort),
      .sel(sel_q), .tick(conv_tick)
   );

   sar_engine #(.RES_W(RES_W)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .tick(conv_tick), .launch(launch), .abort(abort),
      .launch_chan(new_chan), .cmp_in(cmp_in),
      .trial(trial_code), .chan(chan_sel),
      .done(done), .done_val(done_val)
   );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int RES_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [1:0]       bus_addr,
   input logic [7:0]       bus_wdata,
   input logic             start_q,
   input logic             eoc_q,
   input logic [2:0]       sel_q,
   input logic [RES_W-1:0] res_q,
   input logic             adc_pd,
   input logic             conv_tick
);

   // R2: a rising start write marks the converter busy on the next cycle
   assert_busy_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0 && bus_wdata[7] && !start_q) |=> eoc_q);

   // R3: the busy flag falls only on a converter tick
   assert_fall_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eoc_q) |-> $past(conv_tick));

   // R7: no tick while the converter is powered down
   assert_no_tick_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      adc_pd |-> !conv_tick);

   // R9: no tick on an illegal clock code
   assert_no_tick_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[1:0] == 2'b11) |-> !conv_tick);

   // R11: result changes only together with the busy flag falling
   assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(eoc_q) |-> $stable(res_q));

endmodule

bind sar_seq_top sar_seq_chk #(.RES_W(RES_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .start_q(start_q), .eoc_q(eoc_q),
   .sel_q(sel_q), .res_q(res_q), .adc_pd(adc_pd), .conv_tick(conv_tick)
);

// File: tb/sar_seq_top_tb.sv
module sar_seq_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic        cmp_in;
   logic [11:0] trial_code;
   logic [1:0]  chan_sel;
   logic [3:0]  pin_analog;
   logic        adc_pd;
   logic        conv_tick;

   logic [11:0] ain [4];
   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   assign cmp_in = (ain[chan_sel] >= trial_code);

   sar_seq_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
      .trial_code(trial_code), .chan_sel(chan_sel), .pin_analog(pin_analog),
      .adc_pd(adc_pd), .conv_tick(conv_tick)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // waits for busy to clear, returns cycles waited after the launch write
   task automatic wait_done(output int n);
      logic [7:0] c;
      n = 0;
      rd(2'd0, c);
      while (c[6] && n < 5000) begin
         @(negedge clk);
         n++;
         rd(2'd0, c);
      end
   endtask

   task automatic launch(input logic [1:0] ch, input logic [3:0] pins);
      wr(2'd0, {2'b10, pins, ch});
      wr(2'd0, {2'b00, pins, ch});
   endtask

   task automatic check_result(input string req, input logic [11:0] v);
      logic [7:0] h, l;
      rd(2'd2, h);
      rd(2'd3, l);
      check({req, " high"}, h, v[11:4]);
      check({req, " low"}, l, {v[3:0], 4'h0});
   endtask

   task automatic t_reset;
      logic [7:0] d;
      rd(2'd0, d); check("R1 ctrl", d, 8'h40);
      rd(2'd1, d); check("R1 clkp", d, 8'h00);
      check("R1 pins", pin_analog, 0);
      check("R1 pd", adc_pd, 1);
   endtask

   task automatic t_convert(input logic [1:0] ch, input logic [2:0] sel,
                            input logic [11:0] v, input int div);
      int n;
      ain[ch] = v;
      wr(2'd1, {5'b0, sel});
      launch(ch, 4'hF);
      check("R5 chan_sel", chan_sel, ch);
      wait_done(n);
      check("R3/R8 cycles", n, 13 * div);
      check_result("R4/R10 result", v);
   endtask

   task automatic t_chan_latch;
      int n;
      ain[1] = 12'h5A5; ain[2] = 12'h0F0;
      wr(2'd1, 8'h04);
      launch(2'd1, 4'hF);
      wr(2'd0, {2'b00, 4'hF, 2'd2});
      check("R5 latched", chan_sel, 1);
      wait_done(n);
      check_result("R5 result", 12'h5A5);
   endtask

   task automatic t_abort;
      logic [7:0] d;
      int n;
      ain[3] = 12'h123;
      wr(2'd1, 8'h04);
      launch(2'd3, 4'hF);
      wait_done(n);
      check_result("R2 prior", 12'h123);
      ain[3] = 12'hABC;
      launch(2'd3, 4'hF);
      wait_cyc(5);
      wr(2'd0, {2'b10, 4'hF, 2'd3});
      rd(2'd0, d); check("R2 busy", d[6], 1);
      check_result("R2 kept", 12'h123);
      wait_cyc(40);
      rd(2'd0, d); check("R2 still busy", d[6], 1);
      check_result("R2 kept later", 12'h123);
   endtask

   task automatic t_freeze;
      logic [7:0] d;
      int n;
      ain[0] = 12'h7E1;
      wr(2'd1, 8'h04);
      launch(2'd0, 4'h1);
      wait_cyc(4);
      wr(2'd0, {2'b00, 4'h0, 2'd0});
      check("R6 pd pins clear", adc_pd, 1);
      wait_cyc(50);
      rd(2'd0, d); check("R6 frozen", d[6], 1);
      wr(2'd0, {2'b00, 4'h4, 2'd0});
      check("R6 pins out", pin_analog, 4'h4);
      wait_cyc(2);
      wr(2'd1, 8'h44);
      check("R7 pd bit", adc_pd, 1);
      wait_cyc(50);
      rd(2'd0, d); check("R7 frozen", d[6], 1);
      wr(2'd1, 8'h07);
      wait_cyc(50);
      rd(2'd0, d); check("R9 frozen", d[6], 1);
      wr(2'd1, 8'h04);
      check("R7 pd off", adc_pd, 0);
      wait_done(n);
      check_result("R6 resumed", 12'h7E1);
   endtask

   task automatic t_ticks;
      logic [2:0] codes [6] = '{3'b100, 3'b000, 3'b101, 3'b001, 3'b110, 3'b010};
      int n;
      wr(2'd0, {2'b00, 4'hF, 2'd0});
      for (int k = 0; k < 6; k++) begin
         wr(2'd1, {5'b0, codes[k]});
         wait_cyc(40);
         n = 0;
         for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (conv_tick) n++;
         end
         check("R8 tick count", n, 64 >> k);
      end
      for (int k = 0; k < 2; k++) begin
         wr(2'd1, k ? 8'h07 : 8'h03);
         n = 0;
         for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (conv_tick) n++;
         end
         check("R9 no ticks", n, 0);
      end
   endtask

   task automatic t_layout;
      logic [7:0] d;
      wr(2'd1, 8'hFF);
      rd(2'd1, d); check("R10 clkp readback", d, 8'h47);
      check("R7 pd set", adc_pd, 1);
      wr(2'd1, 8'h04);
   endtask

   initial begin
      ain[0] = '0; ain[1] = '0; ain[2] = '0; ain[3] = '0;
      wait_cyc(3);
      t_reset();
      rst_n = 1'b1;
      wait_cyc(2);
      t_reset();
      t_convert(2'd0, 3'b100, 12'hA5C, 1);
      t_convert(2'd1, 3'b101, 12'hFFF, 4);
      t_convert(2'd2, 3'b000, 12'h000, 2);
      t_convert(2'd3, 3'b100, 12'h801, 1);
      t_convert(2'd2, 3'b001, 12'h3C7, 8);
      t_chan_latch();
      t_abort();
      t_freeze();
      t_ticks();
      t_layout();
      done_flag = 1'b1;
   end

   initial begin
      fork
         wait (done_flag);
         begin
            repeat (150000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule